// File: doc/BRIEF.md
# Packed-Syllable Instruction Sequencer

This block is the front end of a small stack machine. It requests 32-bit instruction words from an instruction memory and sorts each word by its two top bits into one of three kinds. A word with bit 31 set carries a single long immediate, which is issued as one push operation. A word whose top bits are 01 is reserved: it stops the sequencer and raises an illegal-instruction flag. A word whose top bits are 00 holds five 6-bit syllables, which are issued one at a time.

Every issued operation is decoded into an operation class and a small operand, and is offered on a valid/ready output. The operand is an immediate value or a stack offset. Alongside each operation the block shows its word-address program counter and its syllable counter. The execution stage can redirect the fetch stream after a jump or a taken branch, and a HALT syllable stops the block for good until reset. Executing the operations and the data memory are handled elsewhere.

Top module: `syllable_sequencer`

## Requirements
- R1: After synchronous reset, `imem_req` is 1 with `imem_addr` = RESET_PC (0 by default), and `op_valid`, `halted` and `illegal` are all 0.
- R2: A fetched word with bit 31 = 1 is issued as exactly one operation of class 18 (push). Its operand is the word's bits 30:0 shifted left by one place with bit 0 = 0, and `op_sc` reads 0. The next word is fetched after it.
- R3: A fetched word with bits 31:30 = 00 is issued as five operations, taken from bits 29:24, 23:18, 17:12, 11:6 and 5:0 in that order.
- R4: While operations from the word at address A are offered, `op_pc` = A+4. For syllable k (k = 0 for bits 29:24, up to k = 4), `op_sc` = (k+1) mod 5, so the middle syllable shows 3 and the last shows 0.
- R5: Syllable decode works as follows. 1xxxxx gives class 18 with the operand set to the 5-bit value zero-extended. 011xxx gives class 16 (copy from stack offset) with the operand x. 010xxx gives class 17 (pop and store to stack offset) with the operand x. 00cccc gives class cccc (0 halt, 1 nop, 7 branch-if-zero, 10 not, 12 add, 13 swap, and so on) with the operand 0.
- R6: While `redir_valid` is 1 and the block has not stopped, `op_valid` and `imem_req` are 0. On the next cycle the block fetches from `redir_pc`, and the syllables left in the current word are never issued.
- R7: A fetched word with bits 31:30 = 01 sets `illegal`. No operation is issued for it and no further fetch is made.
- R8: A HALT syllable (class 0) is offered and accepted like any other operation. After that, `halted` is 1 and no operation or fetch follows, even when a redirect is driven.
- R9: While `op_valid` is 1 and `op_ready` is 0, the offered class, operand and counter stay unchanged. Backpressure neither drops nor repeats an operation.
- R10: While `imem_valid` is 0, `imem_req` stays 1 and `imem_addr` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_req | output | 1 | Instruction fetch request |
| imem_addr | output | 32 | Byte address of the requested word |
| imem_valid | input | 1 | Instruction word available this cycle |
| imem_rdata | input | 32 | Instruction word |
| op_valid | output | 1 | Decoded operation offered |
| op_ready | input | 1 | Consumer accepts the offered operation |
| op_class | output | 5 | Operation class code |
| op_arg | output | 32 | Operand (immediate or stack offset) |
| op_pc | output | 32 | Program counter (address of the next word) |
| op_sc | output | 3 | Syllable counter (next syllable, 0 to 4) |
| redir_valid | input | 1 | Redirect request from a jump or taken branch |
| redir_pc | input | 32 | Redirect target address |
| halted | output | 1 | HALT has been accepted |
| illegal | output | 1 | Reserved-format word was fetched |

## Verification
A syllable index that is off by one shows up at the next handshake, as the wrong class or operand, or as the wrong `op_sc` next to the right class. A program counter that is stale or that advances too often shows up in `op_pc` during the very first operation of a word, and in `imem_addr` at the next fetch. A missed redirect or a state that does not stop shows up within one cycle, as an operation offered when it should not be or a fetch request after the block has stopped. The bench compares every accepted operation against an expected sequence, runs it with and without backpressure, and checks that the block stays quiet for several cycles after each stop.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int XLEN    = 32;
    localparam int SYL_W   = 6;
    localparam int NUM_SYL = 5;
    localparam int SYL_BITS = SYL_W * NUM_SYL;
    localparam int IDX_W   = $clog2(NUM_SYL);
    localparam int CLASS_W = 5;
    localparam int KEEP_W  = XLEN - 1;
    localparam int SIMM_W  = 5;
    localparam int OFS_W   = 3;

    typedef enum logic [CLASS_W-1:0] {
        OPC_HALT  = 5'd0,
        OPC_NOP   = 5'd1,
        OPC_LOAD  = 5'd2,
        OPC_STORE = 5'd3,
        OPC_SHIFT = 5'd4,
        OPC_CAS   = 5'd5,
        OPC_TEST  = 5'd6,
        OPC_BRZ   = 5'd7,
        OPC_AND   = 5'd8,
        OPC_OR    = 5'd9,
        OPC_NOT   = 5'd10,
        OPC_XOR   = 5'd11,
        OPC_ADD   = 5'd12,
        OPC_SWAP  = 5'd13,
        OPC_JMP   = 5'd14,
        OPC_CTXSW = 5'd15,
        OPC_PEEK  = 5'd16,
        OPC_POKE  = 5'd17,
        OPC_PUSH  = 5'd18
    } op_class_e;

    typedef enum logic [1:0] {
        FMT_SYL  = 2'd0,
        FMT_LONG = 2'd1,
        FMT_RSVD = 2'd2
    } word_fmt_e;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_ISSUE = 2'd1,
        ST_STOP  = 2'd2
    } seq_state_e;

    typedef struct packed {
        op_class_e        cls;
        logic [XLEN-1:0]  arg;
    } dec_op_t;

    function automatic word_fmt_e fmt_of(input logic [1:0] tag);
        if (tag[1])      return FMT_LONG;
        else if (tag[0]) return FMT_RSVD;
        else             return FMT_SYL;
    endfunction

    function automatic logic [XLEN-1:0] long_imm(input logic [KEEP_W-1:0] body);
        return {body, 1'b0};
    endfunction

endpackage

// File: rtl/word_classifier.sv
module word_classifier
    import seq_pkg::*;
(
    input  logic [1:0] tag,
    output word_fmt_e  fmt
);
    always_comb fmt = fmt_of(tag);
endmodule

// File: rtl/syllable_picker.sv
module syllable_picker #(
    parameter int SW    = 6,
    parameter int NS    = 5,
    parameter int IW    = $clog2(NS),
    localparam int BITS = SW * NS
) (
    input  logic [BITS-1:0] body,
    input  logic [IW-1:0]   idx,
    output logic [SW-1:0]   syl
);
    logic [SW-1:0] slot [NS];

    for (genvar g = 0; g < NS; g++) begin : g_slot
        assign slot[g] = body[(NS-1-g)*SW +: SW];
    end

    always_comb begin
        syl = '0;
        for (int i = 0; i < NS; i++) begin
            if (idx == IW'(i)) syl = slot[i];
        end
    end
endmodule

// File: rtl/syllable_decoder.sv
module syllable_decoder
    import seq_pkg::*;
(
    input  logic [SYL_W-1:0] syl,
    output dec_op_t          dec
);
    always_comb begin
        dec.arg = '0;
        if (syl[5]) begin
            dec.cls = OPC_PUSH;
            dec.arg = {{(XLEN-SIMM_W){1'b0}}, syl[SIMM_W-1:0]};
        end else if (syl[4]) begin
            dec.cls = syl[3] ? OPC_PEEK : OPC_POKE;
            dec.arg = {{(XLEN-OFS_W){1'b0}}, syl[OFS_W-1:0]};
        end else begin
            dec.cls = op_class_e'({1'b0, syl[3:0]});
        end
    end
endmodule

// File: rtl/syllable_sequencer.sv
module syllable_sequencer
    import seq_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic                clk,
    input  logic                rst,
    output logic                imem_req,
    output logic [XLEN-1:0]     imem_addr,
    input  logic                imem_valid,
    input  logic [XLEN-1:0]     imem_rdata,
    output logic                op_valid,
    input  logic                op_ready,
    output logic [CLASS_W-1:0]  op_class,
    output logic [XLEN-1:0]     op_arg,
    output logic [XLEN-1:0]     op_pc,
    output logic [IDX_W-1:0]    op_sc,
    input  logic                redir_valid,
    input  logic [XLEN-1:0]     redir_pc,
    output logic                halted,
    output logic                illegal
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SYL - 1);
    localparam logic [XLEN-1:0]  WORD_STEP = XLEN'(XLEN / 8);

    seq_state_e        state_q;
    logic [XLEN-1:0]   pc_q;
    logic [KEEP_W-1:0] word_q;
    word_fmt_e         fmt_q;
    logic [IDX_W-1:0]  sidx_q;
    logic              halted_q;
    logic              illegal_q;

    word_fmt_e         fetch_fmt;
    logic [SYL_W-1:0]  cur_syl;
    dec_op_t           syl_op;
    dec_op_t           out_op;
    logic              take_op;

    word_classifier u_class (
        .tag (imem_rdata[XLEN-1 -: 2]),
        .fmt (fetch_fmt)
    );

    syllable_picker #(.SW(SYL_W), .NS(NUM_SYL), .IW(IDX_W)) u_pick (
        .body (word_q[SYL_BITS-1:0]),
        .idx  (sidx_q),
        .syl  (cur_syl)
    );

    syllable_decoder u_dec (
        .syl (cur_syl),
        .dec (syl_op)
    );

    always_comb begin
        if (fmt_q == FMT_LONG) begin
            out_op.cls = OPC_PUSH;
            out_op.arg = long_imm(word_q);
        end else begin
            out_op = syl_op;
        end
    end

    assign imem_req  = (state_q == ST_FETCH) && !redir_valid;
    assign imem_addr = pc_q;
    assign op_valid  = (state_q == ST_ISSUE) && !redir_valid;
    assign take_op   = op_valid && op_ready;
    assign op_class  = out_op.cls;
    assign op_arg    = out_op.arg;
    assign op_pc     = pc_q;
    assign op_sc     = (fmt_q == FMT_LONG || sidx_q == LAST_IDX) ? '0
                                                                  : sidx_q + IDX_W'(1);
    assign halted    = halted_q;
    assign illegal   = illegal_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_FETCH;
            pc_q      <= RESET_PC;
            word_q    <= '0;
            fmt_q     <= FMT_SYL;
            sidx_q    <= '0;
            halted_q  <= 1'b0;
            illegal_q <= 1'b0;
        end else if (state_q != ST_STOP && redir_valid) begin
            pc_q    <= redir_pc;
            sidx_q  <= '0;
            state_q <= ST_FETCH;
        end else begin
            case (state_q)
                ST_FETCH: begin
                    if (imem_valid) begin
                        word_q <= imem_rdata[KEEP_W-1:0];
                        fmt_q  <= fetch_fmt;
                        pc_q   <= pc_q + WORD_STEP;
                        sidx_q <= '0;
                        if (fetch_fmt == FMT_RSVD) begin
                            illegal_q <= 1'b1;
                            state_q   <= ST_STOP;
                        end else begin
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (take_op) begin
                        if (out_op.cls == OPC_HALT) begin
                            halted_q <= 1'b1;
                            state_q  <= ST_STOP;
                        end else if (fmt_q == FMT_LONG || sidx_q == LAST_IDX) begin
                            state_q <= ST_FETCH;
                        end else begin
                            sidx_q <= sidx_q + IDX_W'(1);
                        end
                    end
                end
                default: state_q <= ST_STOP;
            endcase
        end
    end
endmodule

// File: rtl/seq_chk.sv
module seq_chk
    import seq_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                imem_req,
    input logic [XLEN-1:0]     imem_addr,
    input logic                imem_valid,
    input logic [XLEN-1:0]     imem_rdata,
    input logic                op_valid,
    input logic                op_ready,
    input logic [CLASS_W-1:0]  op_class,
    input logic [XLEN-1:0]     op_arg,
    input logic [XLEN-1:0]     op_pc,
    input logic [IDX_W-1:0]    op_sc,
    input logic                redir_valid,
    input logic [XLEN-1:0]     redir_pc,
    input logic                halted,
    input logic                illegal
);
    p_sc_range_r4: assert property (@(posedge clk) disable iff (rst)
        op_valid |-> (op_sc < IDX_W'(NUM_SYL)));

    p_redirect_r6: assert property (@(posedge clk) disable iff (rst)
        (redir_valid && !halted && !illegal) |=>
            (redir_valid || (imem_req && imem_addr == $past(redir_pc))));

    p_illegal_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        illegal |=> (illegal && !op_valid && !imem_req));

    p_halt_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !op_valid && !imem_req));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_ready) |=>
            (redir_valid || (op_valid && $stable(op_class) && $stable(op_arg)
                             && $stable(op_sc) && $stable(op_pc))));

    p_fetch_wait_r10: assert property (@(posedge clk) disable iff (rst)
        (imem_req && !imem_valid) |=>
            (redir_valid || (imem_req && $stable(imem_addr))));
endmodule

bind syllable_sequencer seq_chk u_chk (.*);

// File: tb/tb_syllable_sequencer.sv
module tb_syllable_sequencer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        imem_req, imem_valid, op_valid, op_ready, redir_valid;
    logic [31:0] imem_addr, imem_rdata, op_arg, op_pc, redir_pc;
    logic [4:0]  op_class;
    logic [2:0]  op_sc;
    logic        halted, illegal;
    logic        mem_stall = 1'b0;
    logic        ready_toggle = 1'b0;
    logic        ready_fixed = 1'b1;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    syllable_sequencer dut (
        .clk(clk), .rst(rst),
        .imem_req(imem_req), .imem_addr(imem_addr),
        .imem_valid(imem_valid), .imem_rdata(imem_rdata),
        .op_valid(op_valid), .op_ready(op_ready),
        .op_class(op_class), .op_arg(op_arg), .op_pc(op_pc), .op_sc(op_sc),
        .redir_valid(redir_valid), .redir_pc(redir_pc),
        .halted(halted), .illegal(illegal)
    );

    logic [31:0] mem [8];
    assign imem_rdata = mem[imem_addr[4:2]];
    assign imem_valid = !mem_stall;

    localparam logic [31:0] PROG [4] = '{
        {2'b00, 6'b110101, 6'b011011, 6'b010101, 6'b001100, 6'b001101},
        {2'b00, 6'b000001, 6'b001010, 6'b000111, 6'b011000, 6'b111111},
        32'hC040_4040,
        {2'b00, 6'b000001, 6'b000000, 6'b001000, 6'b001000, 6'b001000}
    };

    typedef struct packed {
        logic [4:0]  cls;
        logic [31:0] arg;
        logic [31:0] pc;
        logic [2:0]  sc;
    } exp_t;

    localparam int NEXP = 13;
    localparam exp_t EXP [NEXP] = '{
        '{5'd18, 32'd21,         32'd4,  3'd1},
        '{5'd16, 32'd3,          32'd4,  3'd2},
        '{5'd17, 32'd5,          32'd4,  3'd3},
        '{5'd12, 32'd0,          32'd4,  3'd4},
        '{5'd13, 32'd0,          32'd4,  3'd0},
        '{5'd1,  32'd0,          32'd8,  3'd1},
        '{5'd10, 32'd0,          32'd8,  3'd2},
        '{5'd7,  32'd0,          32'd8,  3'd3},
        '{5'd16, 32'd0,          32'd8,  3'd4},
        '{5'd18, 32'd31,         32'd8,  3'd0},
        '{5'd18, 32'h8080_8080,  32'd12, 3'd0},
        '{5'd1,  32'd0,          32'd16, 3'd1},
        '{5'd0,  32'd0,          32'd16, 3'd2}
    };

    exp_t cap [32];
    int   n_cap = 0;

    assign op_ready = ready_fixed | ready_toggle;

    always @(negedge clk) begin
        #1;
        if (!rst && op_valid && op_ready && n_cap < 32) begin
            cap[n_cap] = '{op_class, op_arg, op_pc, op_sc};
            n_cap++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish, act=%0d exp<20000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic load_prog();
        for (int i = 0; i < 8; i++) mem[i] = (i < 4) ? PROG[i] : 32'h0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        redir_valid = 1'b0;
        redir_pc = 32'h0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        n_cap = 0;
    endtask

    task automatic wait_halt();
        for (int i = 0; i < 200 && !halted; i++) @(negedge clk);
    endtask

    task automatic compare_run(input string tag);
        chk(n_cap == NEXP, "R8", {tag, " op count"}, n_cap, NEXP);
        for (int i = 0; i < NEXP && i < n_cap; i++) begin
            chk(cap[i].cls == EXP[i].cls, "R5", {tag, " class"}, cap[i].cls, EXP[i].cls);
            chk(cap[i].arg == EXP[i].arg, "R3", {tag, " operand"}, cap[i].arg, EXP[i].arg);
            chk(cap[i].pc == EXP[i].pc && cap[i].sc == EXP[i].sc, "R4", {tag, " pc/sc"},
                {cap[i].pc, 29'd0, cap[i].sc}, {EXP[i].pc, 29'd0, EXP[i].sc});
        end
    endtask

    initial begin
        redir_valid = 1'b0;
        redir_pc = 32'h0;
        load_prog();

        // Run 1: fetch stall after reset, then free-running consumer
        mem_stall = 1'b1;
        do_reset();
        #2;
        chk(imem_req == 1'b1 && imem_addr == 32'h0, "R1", "reset fetch", {imem_req, imem_addr}, 33'h0_0000_0000 | (33'h1 << 32));
        chk(!op_valid && !halted && !illegal, "R1", "reset outputs quiet", {op_valid, halted, illegal}, 3'b000);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #2;
            chk(imem_req && imem_addr == 32'h0 && !op_valid, "R10", "stall hold",
                {imem_req, op_valid, imem_addr}, {1'b1, 1'b0, 32'h0});
        end
        mem_stall = 1'b0;
        wait_halt();
        chk(halted == 1'b1, "R8", "halted after HALT", halted, 1'b1);
        compare_run("run1");
        chk(cap[10].cls == 5'd18 && cap[10].sc == 3'd0, "R2", "long immediate push",
            {cap[10].cls, cap[10].sc}, {5'd18, 3'd0});

        // R8: redirect after halt is ignored
        @(negedge clk);
        redir_valid = 1'b1;
        redir_pc = 32'h0;
        @(negedge clk);
        redir_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #2;
            chk(!imem_req && !op_valid && halted, "R8", "quiet after halt + redirect",
                {imem_req, op_valid, halted}, 3'b001);
        end

        // Run 2: consumer with backpressure
        ready_fixed = 1'b0;
        do_reset();
        fork
            begin
                for (int i = 0; i < 200 && !halted; i++) begin
                    @(negedge clk);
                    ready_toggle = (i % 3) == 2;
                end
            end
            wait_halt();
        join
        ready_fixed = 1'b1;
        ready_toggle = 1'b0;
        chk(halted == 1'b1, "R9", "halted under backpressure", halted, 1'b1);
        compare_run("run2_R9");

        // Run 3: redirect while the second syllable is offered
        do_reset();
        for (int i = 0; i < 50 && !(op_valid && op_sc == 3'd2); i++) @(negedge clk);
        redir_valid = 1'b1;
        redir_pc = 32'd8;
        #2;
        chk(!op_valid && !imem_req, "R6", "redirect gates outputs", {op_valid, imem_req}, 2'b00);
        @(negedge clk);
        redir_valid = 1'b0;
        #2;
        chk(imem_req && imem_addr == 32'd8, "R6", "fetch at redirect target",
            {imem_req, imem_addr}, {1'b1, 32'd8});
        wait_halt();
        chk(n_cap == 4, "R6", "ops after redirect", n_cap, 4);
        chk(cap[0].cls == 5'd18 && cap[0].arg == 32'd21, "R6", "op before redirect",
            {cap[0].cls, cap[0].arg}, {5'd18, 32'd21});
        chk(cap[1].cls == 5'd18 && cap[1].arg == 32'h8080_8080 && cap[1].pc == 32'd12, "R6",
            "first op at target", {cap[1].arg, cap[1].pc}, {32'h8080_8080, 32'd12});
        chk(cap[3].cls == 5'd0 && cap[3].sc == 3'd2, "R8", "halt syllable offered",
            {cap[3].cls, cap[3].sc}, {5'd0, 3'd2});

        // Run 4: reserved word bits 31:30 = 01
        mem[0] = 32'h4000_0000;
        do_reset();
        repeat (6) @(negedge clk);
        #2;
        chk(illegal == 1'b1 && halted == 1'b0, "R7", "illegal flag", {illegal, halted}, 2'b10);
        chk(n_cap == 0 && !op_valid, "R7", "no op issued", n_cap, 0);
        chk(!imem_req, "R7", "no further fetch", imem_req, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule